// File: doc/BRIEF.md
# Reversible 5/3 Lifting Column Filter

This block filters one image column at a time with the reversible integer 5/3 wavelet. Samples arrive one per clock, and each column is flagged at its first sample. The block emits the column's coefficients as an interleaved stream: a smoothed (low-pass) value and a detail (high-pass) value in turn, each marked by a tag bit. The column length is given per column on a side input and is captured with the first sample.

The predict and update operations share one processing element, which is a pair of adders plus a halving stage. A predict on one cycle is always followed by an update on the next, so a single element finishes a whole lifting step every two cycles. The rounding offset of the update is a constant bit pattern placed below the even sample, so no extra adder is needed for it. At each end of the column, symmetric extension reuses the held even sample instead of fetching any sample again. Columns may follow one another with no idle cycle between them, or with gaps.

Top module: `wvlt_col_lift53`

## Requirements
- R1: While reset is asserted, and until the first coefficient is due, `out_valid` stays low.
- R2: A high-pass coefficient at an interior position is d[n] = x[2n+1] − floor((x[2n] + x[2n+2]) / 2).
- R3: A low-pass coefficient at an interior position is s[n] = x[2n] + floor((d[n−1] + d[n] + 2) / 4).
- R4: At the column start, the update uses d[0] in place of the missing d[−1], so s[0] = x[0] + floor((2·d[0] + 2) / 4).
- R5: At the column end, the prediction mirrors x[N−2] in place of the missing x[N], so the last detail is x[N−1] − x[N−2].
- R6: Coefficients leave in input order: s[n] with `out_hi` = 0, then d[n] with `out_hi` = 1 on the next cycle.
- R7: For a column fed without gaps, the coefficient for input position k is valid in the cycle after the fourth rising edge that follows the edge that captured sample k.
- R8: `col_len` is sampled with the flagged first sample, and each column may use any even length from 4 to MAX_LEN.
- R9: A column may start in the cycle right after the previous column's last sample, and neither column's results are affected.
- R10: `out_valid` is low in every cycle that carries no coefficient, including idle gaps between columns.
- R11: For full-scale signed inputs, every coefficient fits in SAMPLE_W+1 signed bits, so the SAMPLE_W+2-bit output never wraps.
- R12: The transform is lossless: the inverse lifting steps applied to the output stream give back every input sample exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| col_len | input | $clog2(MAX_LEN+1) | Column length, sampled with the first sample of a column |
| in_valid | input | 1 | Input sample present |
| in_sof | input | 1 | Marks the first sample of a column |
| in_data | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | Output coefficient present |
| out_hi | output | 1 | 0 for a low-pass coefficient, 1 for a high-pass coefficient |
| out_data | output | SAMPLE_W+2 | Signed output coefficient |

## Verification
Short ramps and constant columns show that the interior predict and update formulas are applied, because for these inputs the expected details are zero or small and the expected values are easy to confirm by hand. The shortest length, 4, puts both boundary mirrors into the same column. Columns that alternate between full-scale extremes drive the widest intermediate sums and show whether any value wraps. Random data in random even lengths, fed either back to back or with idle gaps, separates a correct end-of-column drain from state that leaks into the next column, and a round-trip inverse over every column confirms the lossless claim.

// File: rtl/wv_lift_pkg.sv
// Shared definitions for the 5/3 lifting column filter.
// Assumes nothing beyond the two operating phases of the shared element.
package wv_lift_pkg;

    // Phase of the shared arithmetic element.
    typedef enum logic {
        PE_PREDICT = 1'b0,
        PE_UPDATE  = 1'b1
    } pe_mode_e;

    // Fraction bits carried inside the element's final adder.
    localparam int FRAC_BITS = 2;

endpackage

// File: rtl/wv_lift_pe.sv
// Shared lifting element: one pair-adder plus a final adder, purely combinational.
// Predict phase: res = b - floor((a0 + a1) / 2).
// Update phase:  res = b + floor((a0 + a1 + 2) / 4), with the +2 placed as a
// constant bit below b, so no third adder is needed.
// Assumes operands are IW wide and fit with one guard bit of headroom.
module wv_lift_pe
    import wv_lift_pkg::*;
#(
    parameter int IW = 12
) (
    input  pe_mode_e              mode,
    input  logic signed [IW-1:0]  a0,
    input  logic signed [IW-1:0]  a1,
    input  logic signed [IW-1:0]  b,
    output logic signed [IW-1:0]  res
);

    localparam int SW = IW + 1;
    localparam int FW = IW + FRAC_BITS + 1;

    logic signed [SW-1:0] pair_sum;
    logic signed [SW-1:0] half_sum;
    logic signed [FW-1:0] base_fx;
    logic signed [FW-1:0] term_fx;
    logic signed [FW-1:0] total_fx;

    // Pair adder shared by both phases.
    always_comb begin
        pair_sum = SW'(a0) + SW'(a1);
        half_sum = pair_sum >>> 1;
    end

    // Operand selection for the final adder, in a fixed-point domain with two fraction bits.
    always_comb begin
        base_fx = FW'(b) <<< FRAC_BITS;
        if (mode == PE_UPDATE) begin
            base_fx = base_fx | FW'(2);
            term_fx = FW'(pair_sum);
        end else begin
            term_fx = -(FW'(half_sum) <<< FRAC_BITS);
        end
        total_fx = base_fx + term_fx;
        res      = IW'(total_fx >>> FRAC_BITS);
    end

endmodule

// File: rtl/wv_lift_ctl.sv
// Input capture, sample holding, boundary control and step sequencing.
// A predict is issued when an even sample beyond position 0 arrives, or one
// cycle after the last sample of a column (mirror case). The cycle after
// every predict runs the update on the same element.
// Assumes samples within one column arrive on consecutive cycles and that
// col_len is even and at least 4.
module wv_lift_ctl
    import wv_lift_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int MAX_LEN  = 64,
    localparam int IW      = SAMPLE_W + 2,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LEN_W-1:0]           col_len,
    input  logic                       in_valid,
    input  logic                       in_sof,
    input  logic signed [SAMPLE_W-1:0] in_data,
    input  logic signed [IW-1:0]       pe_res,
    output pe_mode_e                   pe_mode,
    output logic signed [IW-1:0]       pe_a0,
    output logic signed [IW-1:0]       pe_a1,
    output logic signed [IW-1:0]       pe_b,
    output logic                       upd_now,
    output logic signed [IW-1:0]       det_hold
);

    logic signed [IW-1:0] x_q;
    logic                 v_q;
    logic [LEN_W-1:0]     pos_q;
    logic [LEN_W-1:0]     cnt_q;
    logic [LEN_W-1:0]     len_r;
    logic signed [IW-1:0] even_h;
    logic signed [IW-1:0] odd_h;
    logic                 tail_q;
    logic signed [IW-1:0] even_q;
    logic                 first_q;
    logic signed [IW-1:0] det_q;
    logic signed [IW-1:0] det_prev_q;
    logic                 upd_q;
    logic                 do_pred;

    // Capture the incoming sample, its position and the column length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            v_q   <= 1'b0;
            pos_q <= '0;
            cnt_q <= '0;
            len_r <= '0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                x_q   <= IW'(in_data);
                pos_q <= in_sof ? '0 : cnt_q;
                cnt_q <= in_sof ? LEN_W'(1) : cnt_q + 1'b1;
                if (in_sof) begin
                    len_r <= col_len;
                end
            end
        end
    end

    // Hold the latest even and odd samples; flag the cycle after a column's last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_h <= '0;
            odd_h  <= '0;
            tail_q <= 1'b0;
        end else begin
            tail_q <= v_q && (pos_q == len_r - LEN_W'(1));
            if (v_q) begin
                if (!pos_q[0]) begin
                    even_h <= x_q;
                end else begin
                    odd_h <= x_q;
                end
            end
        end
    end

    // A predict runs on a fresh interior even sample or on the mirrored tail.
    always_comb begin
        do_pred = tail_q || (v_q && !pos_q[0] && (pos_q != '0));
    end

    // Register predict results and sequence the following update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q      <= '0;
            det_prev_q <= '0;
            even_q     <= '0;
            first_q    <= 1'b0;
            upd_q      <= 1'b0;
        end else begin
            upd_q <= do_pred;
            if (do_pred) begin
                det_q   <= pe_res;
                even_q  <= even_h;
                first_q <= !tail_q && (pos_q == LEN_W'(2));
            end
            if (upd_q) begin
                det_prev_q <= det_q;
            end
        end
    end

    // Operand steering for the shared element by phase.
    always_comb begin
        if (upd_q) begin
            pe_mode = PE_UPDATE;
            pe_a0   = first_q ? det_q : det_prev_q;
            pe_a1   = det_q;
            pe_b    = even_q;
        end else begin
            pe_mode = PE_PREDICT;
            pe_a0   = even_h;
            pe_a1   = tail_q ? even_h : x_q;
            pe_b    = odd_h;
        end
    end

    assign upd_now  = upd_q;
    assign det_hold = det_q;

endmodule

// File: rtl/wv_lift_out.sv
// Output ordering: the low-pass result leaves on the update cycle while the
// matching detail is parked one cycle in a delay register, so the stream
// keeps the even/odd order of the input.
// Assumes updates are never issued on two consecutive cycles.
module wv_lift_out #(
    parameter int IW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lo_valid,
    input  logic signed [IW-1:0] lo_data,
    input  logic signed [IW-1:0] hi_data,
    output logic                 out_valid,
    output logic                 out_hi,
    output logic signed [IW-1:0] out_data
);

    logic signed [IW-1:0] hi_dly;
    logic                 hi_pend;

    // Emit low-pass now, detail one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hi    <= 1'b0;
            out_data  <= '0;
            hi_dly    <= '0;
            hi_pend   <= 1'b0;
        end else begin
            out_valid <= lo_valid || hi_pend;
            if (lo_valid) begin
                out_data <= lo_data;
                out_hi   <= 1'b0;
                hi_dly   <= hi_data;
                hi_pend  <= 1'b1;
            end else if (hi_pend) begin
                out_data <= hi_dly;
                out_hi   <= 1'b1;
                hi_pend  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wvlt_col_lift53.sv
// Top of the reversible 5/3 lifting column filter.
// One sample per clock in, interleaved low/high coefficients out, fixed
// latency for gapless columns. Internal width is two bits above the sample.
// Assumes even column lengths from 4 to MAX_LEN, first sample flagged by in_sof.
module wvlt_col_lift53
    import wv_lift_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int MAX_LEN  = 64,
    localparam int IW      = SAMPLE_W + 2,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LEN_W-1:0]           col_len,
    input  logic                       in_valid,
    input  logic                       in_sof,
    input  logic signed [SAMPLE_W-1:0] in_data,
    output logic                       out_valid,
    output logic                       out_hi,
    output logic signed [IW-1:0]       out_data
);

    pe_mode_e             pe_mode;
    logic signed [IW-1:0] pe_a0;
    logic signed [IW-1:0] pe_a1;
    logic signed [IW-1:0] pe_b;
    logic signed [IW-1:0] pe_res;
    logic                 upd_now;
    logic signed [IW-1:0] det_hold;

    wv_lift_ctl #(
        .SAMPLE_W(SAMPLE_W),
        .MAX_LEN (MAX_LEN)
    ) ctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .col_len (col_len),
        .in_valid(in_valid),
        .in_sof  (in_sof),
        .in_data (in_data),
        .pe_res  (pe_res),
        .pe_mode (pe_mode),
        .pe_a0   (pe_a0),
        .pe_a1   (pe_a1),
        .pe_b    (pe_b),
        .upd_now (upd_now),
        .det_hold(det_hold)
    );

    wv_lift_pe #(
        .IW(IW)
    ) pe_i (
        .mode(pe_mode),
        .a0  (pe_a0),
        .a1  (pe_a1),
        .b   (pe_b),
        .res (pe_res)
    );

    wv_lift_out #(
        .IW(IW)
    ) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_valid (upd_now),
        .lo_data  (pe_res),
        .hi_data  (det_hold),
        .out_valid(out_valid),
        .out_hi   (out_hi),
        .out_data (out_data)
    );

endmodule

// File: rtl/wvlt_col_lift53_chk.sv
// Property checker for the column filter, attached to every instance of the top by bind.
// Observes ports only.
module wvlt_col_lift53_chk #(
    parameter int SAMPLE_W = 10,
    parameter int MAX_LEN  = 64,
    localparam int IW      = SAMPLE_W + 2,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [LEN_W-1:0]           col_len,
    input logic                       in_valid,
    input logic                       in_sof,
    input logic signed [SAMPLE_W-1:0] in_data,
    input logic                       out_valid,
    input logic                       out_hi,
    input logic signed [IW-1:0]       out_data
);

    AST_LO_THEN_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hi) |=> (out_valid && out_hi)); // R6

    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hi) |-> $past(out_valid && !out_hi)); // R6

    AST_FIRST_COEF_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> ##4 (out_valid && !out_hi)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[IW-1] == out_data[IW-2])); // R11

endmodule

bind wvlt_col_lift53 wvlt_col_lift53_chk #(
    .SAMPLE_W(SAMPLE_W),
    .MAX_LEN (MAX_LEN)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .col_len  (col_len),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_hi   (out_hi),
    .out_data (out_data)
);

// File: tb/wvlt_col_lift53_tb_top.sv
// Self-checking bench: behavioural 5/3 model, per-cycle expectations, round-trip inverse.
module wvlt_col_lift53_tb_top;

    localparam int SW = 10;
    localparam int ML = 64;
    localparam int LW = $clog2(ML + 1);
    localparam int OW = SW + 2;
    localparam int VMAX = (1 << (SW - 1)) - 1;
    localparam int VMIN = -(1 << (SW - 1));

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [LW-1:0]        col_len = '0;
    logic                 in_valid = 1'b0;
    logic                 in_sof = 1'b0;
    logic signed [SW-1:0] in_data = '0;
    logic                 out_valid;
    logic                 out_hi;
    logic signed [OW-1:0] out_data;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    ncol = 0;
    bit    done = 1'b0;
    int    prev_gap = 1;

    int    exp_val[int];
    bit    exp_hi[int];
    string exp_req[int];
    string exp_ctx[int];
    int    exp_key[int];
    int    xin[int];
    int    act[int];
    int    lens[int];

    wvlt_col_lift53 #(.SAMPLE_W(SW), .MAX_LEN(ML)) dut_i (
        .clk(clk), .rst_n(rst_n), .col_len(col_len), .in_valid(in_valid),
        .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
        .out_hi(out_hi), .out_data(out_data)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int actual, int expected, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, actual, expected);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Per-cycle comparison of the output ports against the expectations.
    always @(negedge clk) begin
        if (!done) begin
            if (exp_val.exists(cyc)) begin
                check(out_valid == 1'b1, "R7", int'(out_valid), 1, {"coefficient present ", exp_ctx[cyc]});
                if (out_valid) begin
                    check(out_hi == exp_hi[cyc], "R6", int'(out_hi), int'(exp_hi[cyc]), "band tag");
                    check(int'(out_data) == exp_val[cyc], exp_req[cyc], int'(out_data), exp_val[cyc],
                          {"coefficient value ", exp_ctx[cyc]});
                    act[exp_key[cyc]] = int'(out_data);
                end
            end else begin
                check(out_valid == 1'b0, (ncol == 0) ? "R1" : "R10", int'(out_valid), 0, "idle cycle");
            end
        end
    end

    // Build one column, compute its expected coefficients, and drive it.
    task automatic send_col(int len, int kind, int gap);
        int xs[ML];
        int ds[ML/2];
        int ss[ML/2];
        string ctx;
        for (int i = 0; i < len; i++) begin
            case (kind)
                1:       xs[i] = 3 * i - 5;
                2:       xs[i] = VMAX;
                3:       xs[i] = i[0] ? VMIN : VMAX;
                4:       xs[i] = i[0] ? VMAX : VMIN;
                default: xs[i] = int'($urandom_range(VMAX - VMIN)) + VMIN;
            endcase
        end
        for (int n = 0; n < len / 2; n++) begin
            int rt;
            rt = (2 * n + 2 < len) ? xs[2 * n + 2] : xs[len - 2];
            ds[n] = xs[2 * n + 1] - ((xs[2 * n] + rt) >>> 1);
        end
        for (int n = 0; n < len / 2; n++) begin
            int dl;
            dl = (n == 0) ? ds[0] : ds[n - 1];
            ss[n] = xs[2 * n] + ((dl + ds[n] + 2) >>> 2);
        end
        ctx = $sformatf("col %0d len %0d", ncol, len);
        if (len == ML) ctx = {ctx, " R8"};
        if (prev_gap == 0) ctx = {ctx, " R9"};
        if (kind >= 2 && kind <= 4) ctx = {ctx, " R11"};
        lens[ncol] = len;
        for (int i = 0; i < len; i++) begin
            int key;
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            col_len  = LW'(len);
            in_data  = SW'(xs[i]);
            key = cyc + 5;
            exp_hi[key]  = i[0];
            exp_val[key] = i[0] ? ds[i / 2] : ss[i / 2];
            exp_req[key] = i[0] ? ((i == len - 1) ? "R5" : "R2") : ((i == 0) ? "R4" : "R3");
            exp_ctx[key] = ctx;
            exp_key[key] = ncol * 128 + i;
            xin[ncol * 128 + i] = xs[i];
        end
        ncol++;
        prev_gap = gap;
        repeat (gap) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sof   = 1'b0;
        end
    endtask

    // Inverse lifting over the captured outputs of every column.
    task automatic round_trip();
        for (int c = 0; c < ncol; c++) begin
            int len;
            int rx[ML];
            bit ok;
            int bad_a;
            int bad_e;
            len = lens[c];
            ok = 1'b1;
            bad_a = 0;
            bad_e = 0;
            for (int i = 0; i < len; i++) begin
                if (!act.exists(c * 128 + i)) ok = 1'b0;
            end
            if (ok) begin
                for (int n = 0; n < len / 2; n++) begin
                    int dl;
                    dl = (n == 0) ? act[c * 128 + 1] : act[c * 128 + 2 * n - 1];
                    rx[2 * n] = act[c * 128 + 2 * n] - ((dl + act[c * 128 + 2 * n + 1] + 2) >>> 2);
                end
                for (int n = 0; n < len / 2; n++) begin
                    int rt;
                    rt = (2 * n + 2 < len) ? rx[2 * n + 2] : rx[len - 2];
                    rx[2 * n + 1] = act[c * 128 + 2 * n + 1] + ((rx[2 * n] + rt) >>> 1);
                end
                for (int i = 0; i < len; i++) begin
                    if (ok && rx[i] != xin[c * 128 + i]) begin
                        ok = 1'b0;
                        bad_a = rx[i];
                        bad_e = xin[c * 128 + i];
                    end
                end
            end
            check(ok, "R12", bad_a, bad_e, $sformatf("lossless reconstruction of column %0d", c));
        end
    endtask

    // Stimulus sequence.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        send_col(4, 1, 0);
        send_col(4, 2, 0);
        send_col(4, 3, 3);
        send_col(ML, 0, 0);
        send_col(ML, 4, 2);
        send_col(6, 1, 0);
        send_col(8, 3, 1);
        for (int c = 0; c < 30; c++) begin
            send_col(4 + 2 * int'($urandom_range(ML / 2 - 2)), 0, int'($urandom_range(2)));
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        repeat (20) @(negedge clk);
        round_trip();
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule